// File: doc/BRIEF.md
# Pipeline Stage Stall and Squash Controller

This block is the control state machine of one out-of-order pipeline stage. It sits between a rename stage upstream and a commit stage downstream. Bundles of renamed instructions arrive from upstream with a valid flag. While the stage runs normally, each valid bundle is forwarded straight on to the issue queue. When commit asks for a stall, or the issue queue is full, the stage stops accepting work. It parks arriving bundles in a small skid buffer and holds the upstream stage stalled. Once the stall clears it drains the parked bundles, one per cycle and in arrival order, before it returns to normal running.

A squash request from commit, or a report that the reorder buffer is still squashing, throws the stage into a squash mode. Entering that mode discards the skid buffer and any bundle arriving in that cycle. While either indication is held, the block sends the issue queue a squash-step pulse every cycle. It sends a single stop pulse on the cycle it leaves. The issue queue's free-entry count is passed back upstream every cycle, whatever the mode.

Top module: `stage_ctl`

## Requirements
- R1: After a synchronous reset the mode output reads 0 (Idle), the stall output is low, no bundle is forwarded and the skid buffer is empty. Mode codes: 0 Idle, 1 Running, 2 Blocked, 3 Unblocking, 4 Squashing.
- R2: In Idle or Running, with no stall, no squash indication and the issue queue not full, a valid bundle is forwarded in the same cycle. The first valid bundle moves Idle to Running. Idle stays Idle while no valid bundle arrives.
- R3: In Blocked, the stall output is high every cycle. The bundle arriving in the cycle that enters Blocked is stored in the skid buffer. Every valid bundle that arrives during Blocked is also stored. The buffer holds at most DEPTH bundles, and pushing into a full buffer without a pop is a design error.
- R4: Blocked moves to Unblocking when the commit stall is low and the issue queue is not full, with no squash indication.
- R5: In Unblocking, the oldest stored bundle is forwarded and removed each cycle. The stall output stays high while more than one entry is stored. The mode becomes Running once the buffer is empty after that cycle. A commit stall in Unblocking returns the block to Blocked.
- R6: In Squashing, the block returns to Running only in a cycle where both the commit squash and the reorder-buffer squashing inputs are low. In every other Squashing cycle, the squash-step output is high. Bundles that arrive during Squashing are neither forwarded nor stored.
- R7: A commit squash or reorder-buffer squashing indication in Idle, Running, Blocked or Unblocking moves the block to Squashing. This takes priority over a stall. It empties the skid buffer and drops the arriving bundle.
- R8: In Running, a commit stall moves the block to Blocked. So does a valid bundle arriving while the issue queue is full.
- R9: The free-entry output equals the issue queue's free-entry input in every cycle and every mode.
- R10: On the cycle that leaves Squashing, the stop-squash output is high for exactly that one cycle. The step and stop outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmt_stall_i | input | 1 | Stall request from commit |
| cmt_squash_i | input | 1 | Squash request from commit |
| rob_squashing_i | input | 1 | Reorder buffer still squashing |
| iq_full_i | input | 1 | Issue queue full |
| iq_free_i | input | FREE_W | Free issue-queue entries |
| bnd_valid_i | input | 1 | Incoming bundle valid |
| bnd_data_i | input | BUNDLE_W | Incoming bundle payload |
| stall_o | output | 1 | Stall request to upstream stage |
| free_o | output | FREE_W | Free-entry count passed upstream |
| fwd_valid_o | output | 1 | Bundle forwarded to issue queue |
| fwd_data_o | output | BUNDLE_W | Forwarded bundle payload |
| sq_step_o | output | 1 | Squash-step pulse to issue queue |
| sq_stop_o | output | 1 | Stop-squash pulse to issue queue |
| mode_o | output | 3 | Current mode code |

## Verification
The random phase mixes five inputs, each with its own bias: commit stall, commit squash, reorder-buffer squashing, issue queue full and bundle valid. An upstream model honours the stall output, so the stimulus reaches every mode and most transitions between them. A directed fill then ignores the stall while Blocked until the buffer holds DEPTH bundles. The release that follows shows whether the drain keeps arrival order and when the stall output drops. Further directed runs hold one of the two squash inputs while the other drops. These runs separate a correct exit, which needs both inputs low, from one that leaves when either input falls. One more case raises a squash and a stall together to expose a wrong priority.

// File: rtl/stage_ctl_pkg.sv
package stage_ctl_pkg;

    typedef enum logic [2:0] {
        M_IDLE = 3'd0,
        M_RUN  = 3'd1,
        M_BLK  = 3'd2,
        M_UNB  = 3'd3,
        M_SQ   = 3'd4
    } mode_e;

    // control decisions taken by the mode logic in one cycle
    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
        logic fwd_in;
        logic fwd_skid;
        logic stall;
        logic step;
        logic stop;
    } ctl_t;

    function automatic logic squash_req(input logic sq, input logic rob);
        return sq | rob;
    endfunction

endpackage

// File: rtl/stage_skid_fifo.sv
module stage_skid_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  head_data,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;

    function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= nxt_ptr(wr_ptr);
            if (pop)  rd_ptr <= nxt_ptr(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!flush && push) mem[wr_ptr] <= push_data;
    end

    assign head_data = mem[rd_ptr];
endmodule

// File: rtl/stage_ctl_fsm.sv
module stage_ctl_fsm
    import stage_ctl_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  mode_e         mode,
    input  logic          cmt_stall,
    input  logic          cmt_squash,
    input  logic          rob_squashing,
    input  logic          iq_full,
    input  logic          bnd_valid,
    input  logic [CW-1:0] count,
    output mode_e         mode_nxt,
    output ctl_t          ctl
);
    logic sq_any;
    logic cnt_zero;

    assign sq_any   = squash_req(cmt_squash, rob_squashing);
    assign cnt_zero = (count == '0);

    always_comb begin
        mode_nxt = mode;
        ctl      = '0;
        unique case (mode)
            M_IDLE, M_RUN: begin
                if (sq_any) begin
                    mode_nxt  = M_SQ;
                    ctl.flush = 1'b1;
                end else if (cmt_stall) begin
                    mode_nxt = M_BLK;
                    ctl.push = bnd_valid;
                end else if (bnd_valid && iq_full) begin
                    mode_nxt = M_BLK;
                    ctl.push = 1'b1;
                end else begin
                    ctl.fwd_in = bnd_valid;
                    if (bnd_valid) mode_nxt = M_RUN;
                end
            end
            M_BLK: begin
                ctl.stall = 1'b1;
                if (sq_any) begin
                    mode_nxt  = M_SQ;
                    ctl.flush = 1'b1;
                end else begin
                    ctl.push = bnd_valid;
                    if (!cmt_stall && !iq_full) mode_nxt = M_UNB;
                end
            end
            M_UNB: begin
                ctl.stall = (count > CW'(1));
                if (sq_any) begin
                    mode_nxt  = M_SQ;
                    ctl.flush = 1'b1;
                end else if (cmt_stall) begin
                    mode_nxt = M_BLK;
                    ctl.push = bnd_valid;
                end else begin
                    ctl.pop      = !cnt_zero;
                    ctl.fwd_skid = !cnt_zero;
                    ctl.push     = bnd_valid;
                    if (count <= CW'(1) && !bnd_valid) mode_nxt = M_RUN;
                end
            end
            M_SQ: begin
                if (sq_any) begin
                    ctl.step = 1'b1;
                end else begin
                    ctl.stop = 1'b1;
                    mode_nxt = M_RUN;
                end
            end
            default: mode_nxt = M_IDLE;
        endcase
    end
endmodule

// File: rtl/stage_ctl.sv
module stage_ctl
    import stage_ctl_pkg::*;
#(
    parameter int BUNDLE_W = 32,
    parameter int DEPTH    = 4,
    parameter int FREE_W   = 5,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmt_stall_i,
    input  logic                cmt_squash_i,
    input  logic                rob_squashing_i,
    input  logic                iq_full_i,
    input  logic [FREE_W-1:0]   iq_free_i,
    input  logic                bnd_valid_i,
    input  logic [BUNDLE_W-1:0] bnd_data_i,
    output logic                stall_o,
    output logic [FREE_W-1:0]   free_o,
    output logic                fwd_valid_o,
    output logic [BUNDLE_W-1:0] fwd_data_o,
    output logic                sq_step_o,
    output logic                sq_stop_o,
    output logic [2:0]          mode_o
);
    mode_e             mode_q, mode_d;
    ctl_t              ctl;
    logic [CW-1:0]     cnt_w;
    logic [BUNDLE_W-1:0] head_w;
    logic              push_w, pop_w;

    stage_ctl_fsm #(.DEPTH(DEPTH)) u_fsm (
        .mode          (mode_q),
        .cmt_stall     (cmt_stall_i),
        .cmt_squash    (cmt_squash_i),
        .rob_squashing (rob_squashing_i),
        .iq_full       (iq_full_i),
        .bnd_valid     (bnd_valid_i),
        .count         (cnt_w),
        .mode_nxt      (mode_d),
        .ctl           (ctl)
    );

    assign push_w = ctl.push;
    assign pop_w  = ctl.pop;

    stage_skid_fifo #(.W(BUNDLE_W), .DEPTH(DEPTH)) u_skid (
        .clk       (clk),
        .rst       (rst),
        .push      (push_w),
        .push_data (bnd_data_i),
        .pop       (pop_w),
        .flush     (ctl.flush),
        .head_data (head_w),
        .count     (cnt_w)
    );

    always_ff @(posedge clk) begin
        if (rst) mode_q <= M_IDLE;
        else     mode_q <= mode_d;
    end

    assign stall_o     = ctl.stall;
    assign free_o      = iq_free_i;
    assign fwd_valid_o = ctl.fwd_in | ctl.fwd_skid;
    assign fwd_data_o  = ctl.fwd_skid ? head_w : bnd_data_i;
    assign sq_step_o   = ctl.step;
    assign sq_stop_o   = ctl.stop;
    assign mode_o      = mode_q;
endmodule

// File: rtl/stage_ctl_chk.sv
module stage_ctl_chk
    import stage_ctl_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          cmt_stall_i,
    input logic          cmt_squash_i,
    input logic          rob_squashing_i,
    input logic          iq_full_i,
    input logic          bnd_valid_i,
    input logic          stall_o,
    input logic          sq_step_o,
    input logic          sq_stop_o,
    input logic [2:0]    mode_o,
    input logic [CW-1:0] cnt_w,
    input logic          push_w,
    input logic          pop_w
);
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        !(push_w && !pop_w && cnt_w == CW'(DEPTH)));

    a_r3_blocked_stall: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd2) |-> stall_o);

    a_r4_to_unblock: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd2 && !cmt_stall_i && !iq_full_i && !cmt_squash_i && !rob_squashing_i)
        |=> (mode_o == 3'd3));

    a_r5_drain_done: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd3 && cnt_w == CW'(1) && !bnd_valid_i && !cmt_stall_i
         && !cmt_squash_i && !rob_squashing_i) |=> (mode_o == 3'd1));

    a_r6_sq_exit: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd4 && !cmt_squash_i && !rob_squashing_i) |=> (mode_o == 3'd1));

    a_r6_sq_step: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd4 && (cmt_squash_i || rob_squashing_i)) |-> sq_step_o);

    a_r7_enter_sq: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 3'd4 && (cmt_squash_i || rob_squashing_i)) |=> (mode_o == 3'd4));

    a_r10_pulse_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sq_step_o, sq_stop_o}));

    a_r10_stop_single: assert property (@(posedge clk) disable iff (rst)
        sq_stop_o |=> !sq_stop_o);
endmodule

bind stage_ctl stage_ctl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cmt_stall_i     (cmt_stall_i),
    .cmt_squash_i    (cmt_squash_i),
    .rob_squashing_i (rob_squashing_i),
    .iq_full_i       (iq_full_i),
    .bnd_valid_i     (bnd_valid_i),
    .stall_o         (stall_o),
    .sq_step_o       (sq_step_o),
    .sq_stop_o       (sq_stop_o),
    .mode_o          (mode_o),
    .cnt_w           (cnt_w),
    .push_w          (push_w),
    .pop_w           (pop_w)
);

// File: tb/sim_stage_ctl.sv
module sim_stage_ctl;
    localparam int BW    = 16;
    localparam int DEPTH = 4;
    localparam int FW    = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cstall = 1'b0, csq = 1'b0, rsq = 1'b0, full = 1'b0, vld = 1'b0;
    logic [FW-1:0] free_in = '0;
    logic [BW-1:0] din = '0;
    logic          stall_o, fwd_v, step_o, stop_o;
    logic [FW-1:0] free_o;
    logic [BW-1:0] fwd_d;
    logic [2:0]    mode_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    int          m_mode;
    logic [BW-1:0] m_q[$];
    bit          e_stall, e_fv, e_step, e_stop;
    logic [BW-1:0] e_fd;

    always #4 clk = ~clk;

    stage_ctl #(.BUNDLE_W(BW), .DEPTH(DEPTH), .FREE_W(FW)) u0 (
        .clk(clk), .rst(rst), .cmt_stall_i(cstall), .cmt_squash_i(csq),
        .rob_squashing_i(rsq), .iq_full_i(full), .iq_free_i(free_in),
        .bnd_valid_i(vld), .bnd_data_i(din), .stall_o(stall_o), .free_o(free_o),
        .fwd_valid_o(fwd_v), .fwd_data_o(fwd_d), .sq_step_o(step_o),
        .sq_stop_o(stop_o), .mode_o(mode_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input int m);
        case (m)
            0: return "R2";
            2: return "R3";
            3: return "R5";
            4: return "R6";
            default: return "R8";
        endcase
    endfunction

    // expected outputs for this cycle, then advance the model
    task automatic model_step();
        bit sq = csq | rsq;
        int nm = m_mode;
        e_stall = 0; e_fv = 0; e_step = 0; e_stop = 0; e_fd = din;
        case (m_mode)
            0, 1: begin
                if (sq) begin nm = 4; m_q.delete(); end
                else if (cstall) begin nm = 2; if (vld) m_q.push_back(din); end
                else if (vld && full) begin nm = 2; m_q.push_back(din); end
                else begin e_fv = vld; if (vld) nm = 1; end
            end
            2: begin
                e_stall = 1;
                if (sq) begin nm = 4; m_q.delete(); end
                else begin
                    if (vld) m_q.push_back(din);
                    if (!cstall && !full) nm = 3;
                end
            end
            3: begin
                e_stall = (m_q.size() > 1);
                if (sq) begin nm = 4; m_q.delete(); end
                else if (cstall) begin nm = 2; if (vld) m_q.push_back(din); end
                else begin
                    if (m_q.size() > 0) begin e_fv = 1; e_fd = m_q.pop_front(); end
                    if (vld) m_q.push_back(din);
                    if (m_q.size() == 0) nm = 1;
                end
            end
            default: begin
                if (sq) e_step = 1;
                else begin e_stop = 1; nm = 1; end
            end
        endcase
        check(mode_tag(m_mode), "mode", int'(mode_o), m_mode);
        check("R3", "stall", int'(stall_o), int'(e_stall));
        check("R5", "fwd_valid", int'(fwd_v), int'(e_fv));
        if (e_fv) check("R5", "fwd_data", int'(fwd_d), int'(e_fd));
        check("R6", "sq_step", int'(step_o), int'(e_step));
        check("R10", "sq_stop", int'(stop_o), int'(e_stop));
        check("R9", "free", int'(free_o), int'(free_in));
        m_mode = nm;
    endtask

    // one cycle: drive at negedge, compare, then let the edge happen
    task automatic cyc(input bit st, input bit sq, input bit rb, input bit fl,
                       input bit v, input bit obey);
        @(negedge clk);
        cstall = st; csq = sq; rsq = rb; full = fl;
        free_in = FW'($urandom % 32);
        din = BW'($urandom);
        vld = v && !(obey && stall_o);
        #1;
        model_step();
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        m_mode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "mode", int'(mode_o), 0);
        check("R1", "stall", int'(stall_o), 0);
        check("R1", "fwd_valid", int'(fwd_v), 0);

        // R2: Idle holds without bundles, then runs on first bundle
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 1, 1);
        cyc(0, 0, 0, 0, 1, 1);
        // R8 and R3: stall with a bundle, then fill the buffer ignoring stall
        cyc(1, 0, 0, 0, 1, 1);
        for (int i = 0; i < DEPTH - 1; i++) cyc(1, 0, 0, 0, 1, 0);
        // R4 and R5: release, drain DEPTH bundles in order
        for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 0, 0, 0, 1);
        // R8: iq full with a bundle, then R7: squash beats stall in Blocked
        cyc(0, 0, 0, 1, 1, 1);
        cyc(1, 1, 0, 1, 0, 1);
        // R6: one squash input stays while the other drops
        cyc(0, 0, 1, 0, 1, 1);
        cyc(0, 1, 0, 0, 1, 1);
        cyc(0, 0, 0, 0, 1, 1);   // R10 exit pulse
        cyc(0, 0, 0, 0, 0, 1);
        // R7: squash from Running with a stall and a bundle
        cyc(1, 0, 1, 0, 1, 1);
        cyc(0, 0, 0, 0, 0, 1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 100) < 20, ($urandom % 100) < 5, ($urandom % 100) < 5,
                ($urandom % 100) < 15, ($urandom % 100) < 60, 1);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule